// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down counters behind one byte-wide port with four addresses. Addresses 0, 1 and 2 reach the count register of counter 0, 1 and 2. Address 3 is a control port: a byte written there picks a counter and sets how its count is accessed and how it counts. Every counter drives one output pin. Counter 2 also has a gate input that can pause it. The other two counters are always enabled.

A counter advances once per cycle in which the shared `tick` enable is high. Software loads a count one byte at a time, as the low byte only, the high byte only, or the low byte followed by the high byte. It can also freeze a snapshot of a running counter and read it back while counting goes on. Three counting behaviours are built: a one-time terminal-count flag, a periodic one-tick strobe, and a square wave with automatic reload. To give a frequency f from the 1193182 Hz counting clock, load the count 1193182 / f, rounded to the nearest integer.

Top module: `pit3_top`

## Requirements
- R1: After reset, all three outputs are low. A data read from any counter returns 0x00.
- R2: A write to address 3 is a control word. The counter is chosen by bits 7:6 (value 0, 1 or 2), the access mode by bits 5:4, and the counting mode by bits 3:1. The value 3 in bits 7:6 changes no counter. A control word with a nonzero access field does all of the following: it stops that counter until a new count is loaded, it clears the byte sequencing and any snapshot, and it sets the output low for counting mode 0 and high for modes 2 and 3.
- R3: Access mode 11 works in pairs. The first data write supplies the low byte and the second supplies the high byte. Counting begins only after the high byte has been written. Successive data reads return the low byte and then the high byte, alternately.
- R4: Access mode 01 loads the written byte as the low byte, with the high byte set to zero. Access mode 10 loads the written byte as the high byte, with the low byte set to zero. In either mode, a read returns only the matching byte.
- R5: A control word with access field 00 freezes a snapshot of the chosen counter. Data reads return the snapshot while the counter keeps counting. The snapshot is released by the read that completes the access mode (one read for modes 01 and 10, the second read for mode 11). A further freeze request issued while a snapshot is held has no effect.
- R6: Mode 0 gives a terminal-count flag. The output goes low when a count N is loaded. It goes high after N counting ticks and stays high while the counter wraps and keeps counting.
- R7: Mode 2 gives a periodic strobe with period N. The output is low for exactly the Nth tick of each period and high otherwise, and the count reloads itself.
- R8: Mode 3 gives a square wave with automatic reload. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high after the load.
- R9: Counter 2 advances only while `gate_in` is high. Counters 0 and 1 ignore it.
- R10: A loaded count of zero counts as 65536 ticks.
- R11: Mode codes 1, 4 and 5 behave as mode 0. Codes 6 and 7 behave as 2 and 3.
- R12: Control bit 0, which requests decimal counting, is accepted, but counting stays binary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counting enable shared by all counters |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; advances the read byte sequence |
| addr | input | 2 | 0 to 2 select a counter's data port, 3 selects the control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the addressed counter; 0 at address 3 |
| gate_in | input | 1 | Gate for counter 2 |
| tmr_out | output | 3 | Counter outputs, bit k belongs to counter k |

## Verification
The hardest cases to reach from the ports involve timing across commands. One is a snapshot that must stay frozen while the counter keeps moving. Another is a second freeze request issued before the first snapshot has been read. The stimulus holds `tick` low around every command, so each count is known exactly. It then runs a chosen number of ticks between the freeze requests and the reads. The zero-means-65536 case and the split of odd counts in the square wave are each timed tick by tick against the expected waveform.

// File: rtl/pit3_pkg.sv
`timescale 1ns/1ps
package pit3_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam logic [1:0] CTL_ADDR = 2'd3;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_PAIR = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        MD_FLAG  = 2'd0,
        MD_STROBE = 2'd1,
        MD_SQUARE = 2'd2
    } mode_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  snap;
        logic [BYTE_W-1:0] lo_hold;
        acc_e              acc;
        mode_e             mode;
        logic              run;
        logic              snap_vld;
        logic              wr_hi;
        logic              rd_hi;
        logic              out;
    } chan_st_t;

    function automatic mode_e decode_mode(input logic [2:0] f);
        case (f)
            3'd2, 3'd6: return MD_STROBE;
            3'd3, 3'd7: return MD_SQUARE;
            default:    return MD_FLAG;
        endcase
    endfunction

    // Square wave counts down by two; an odd reload is stretched for the
    // high phase and shortened for the low phase.
    function automatic logic [CNT_W-1:0] sq_load(input logic [CNT_W-1:0] n,
                                                 input logic hi);
        if (!n[0]) return n;
        return hi ? n + 1'b1 : n - 1'b1;
    endfunction
endpackage

// File: rtl/pit3_dec.sv
`timescale 1ns/1ps
module pit3_dec
    import pit3_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NCH-1:0]    ctl_we,
    output logic [NCH-1:0]    snap_req,
    output logic [NCH-1:0]    dat_we,
    output logic [NCH-1:0]    dat_re
);
    always_comb begin
        ctl_we   = '0;
        snap_req = '0;
        dat_we   = '0;
        dat_re   = '0;
        for (int k = 0; k < NCH; k++) begin
            dat_we[k] = wr_en && (addr == 2'(k));
            dat_re[k] = rd_en && (addr == 2'(k));
            if (wr_en && (addr == CTL_ADDR) && (wdata[7:6] == 2'(k))) begin
                if (wdata[5:4] == ACC_SNAP) snap_req[k] = 1'b1;
                else                        ctl_we[k]   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pit3_chan.sv
`timescale 1ns/1ps
module pit3_chan
    import pit3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic              ctl_we,
    input  logic              snap_req,
    input  logic              dat_we,
    input  logic              dat_re,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              out,
    output logic              run,
    output mode_e             mode,
    output logic [CNT_W-1:0]  cnt
);
    localparam chan_st_t RST_ST = '{
        cnt: '0, reload: '0, snap: '0, lo_hold: '0,
        acc: ACC_PAIR, mode: MD_FLAG,
        run: 1'b0, snap_vld: 1'b0, wr_hi: 1'b0, rd_hi: 1'b0, out: 1'b0
    };

    chan_st_t st_q, st_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic [CNT_W-1:0] view;
    mode_e            new_mode;

    always_comb begin
        st_d     = st_q;
        ld       = 1'b0;
        ld_val   = '0;
        new_mode = decode_mode(wdata[3:1]);

        // counting
        if (tick && gate && st_q.run) begin
            case (st_q.mode)
                MD_STROBE: begin
                    if (st_q.cnt == CNT_W'(1)) begin
                        st_d.cnt = st_q.reload;
                        st_d.out = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                        if (st_q.cnt == CNT_W'(2)) st_d.out = 1'b0;
                    end
                end
                MD_SQUARE: begin
                    if (st_q.cnt == CNT_W'(2)) begin
                        st_d.out = !st_q.out;
                        st_d.cnt = sq_load(st_q.reload, !st_q.out);
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(2);
                    end
                end
                default: begin
                    st_d.cnt = st_q.cnt - 1'b1;
                    if (st_q.cnt == CNT_W'(1)) st_d.out = 1'b1;
                end
            endcase
        end

        // snapshot request, ignored while one is held
        if (snap_req && !st_q.snap_vld) begin
            st_d.snap     = st_q.cnt;
            st_d.snap_vld = 1'b1;
        end

        // read byte sequencing
        if (dat_re) begin
            if (st_q.acc == ACC_PAIR) begin
                st_d.rd_hi = !st_q.rd_hi;
                if (st_q.rd_hi) st_d.snap_vld = 1'b0;
            end else begin
                st_d.snap_vld = 1'b0;
            end
        end

        // write byte sequencing
        if (dat_we) begin
            case (st_q.acc)
                ACC_LO: begin
                    ld     = 1'b1;
                    ld_val = {{(CNT_W-BYTE_W){1'b0}}, wdata};
                end
                ACC_HI: begin
                    ld     = 1'b1;
                    ld_val = {wdata, {(CNT_W-BYTE_W){1'b0}}};
                end
                default: begin
                    if (!st_q.wr_hi) begin
                        st_d.lo_hold = wdata;
                        st_d.wr_hi   = 1'b1;
                    end else begin
                        ld         = 1'b1;
                        ld_val     = {wdata, st_q.lo_hold};
                        st_d.wr_hi = 1'b0;
                    end
                end
            endcase
        end

        if (ld) begin
            st_d.reload = ld_val;
            st_d.run    = 1'b1;
            case (st_q.mode)
                MD_STROBE: begin st_d.cnt = ld_val;             st_d.out = 1'b1; end
                MD_SQUARE: begin st_d.cnt = sq_load(ld_val, 1'b1); st_d.out = 1'b1; end
                default:   begin st_d.cnt = ld_val;             st_d.out = 1'b0; end
            endcase
        end

        // control word
        if (ctl_we) begin
            st_d.acc      = acc_e'(wdata[5:4]);
            st_d.mode     = new_mode;
            st_d.run      = 1'b0;
            st_d.wr_hi    = 1'b0;
            st_d.rd_hi    = 1'b0;
            st_d.snap_vld = 1'b0;
            st_d.out      = (new_mode != MD_FLAG);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign view  = st_q.snap_vld ? st_q.snap : st_q.cnt;
    assign rdata = ((st_q.acc == ACC_HI) || (st_q.acc == ACC_PAIR && st_q.rd_hi))
                   ? view[CNT_W-1 -: BYTE_W] : view[BYTE_W-1:0];
    assign out   = st_q.out;
    assign run   = st_q.run;
    assign mode  = st_q.mode;
    assign cnt   = st_q.cnt;
endmodule

// File: rtl/pit3_top.sv
`timescale 1ns/1ps
module pit3_top
    import pit3_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int GATED_CH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        gate_in,
    output logic [2:0]  tmr_out
);
    logic [NCH-1:0]              ctl_we, snap_req, dat_we, dat_re;
    logic [NCH-1:0][BYTE_W-1:0]  ch_rdata;
    logic [NCH-1:0]              ch_out, ch_run;
    mode_e [NCH-1:0]             ch_mode;
    logic [NCH-1:0][CNT_W-1:0]   ch_cnt;

    pit3_dec #(.NCH(NCH)) u_dec (
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .ctl_we   (ctl_we),
        .snap_req (snap_req),
        .dat_we   (dat_we),
        .dat_re   (dat_re)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic gate_k;
        if (k == GATED_CH) begin : g_gated
            assign gate_k = gate_in;
        end else begin : g_free
            assign gate_k = 1'b1;
        end

        pit3_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .gate     (gate_k),
            .ctl_we   (ctl_we[k]),
            .snap_req (snap_req[k]),
            .dat_we   (dat_we[k]),
            .dat_re   (dat_re[k]),
            .wdata    (wdata),
            .rdata    (ch_rdata[k]),
            .out      (ch_out[k]),
            .run      (ch_run[k]),
            .mode     (ch_mode[k]),
            .cnt      (ch_cnt[k])
        );
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NCH; k++) begin
            if (addr == 2'(k)) rdata = ch_rdata[k];
        end
    end

    assign tmr_out = ch_out;
endmodule

// File: rtl/pit3_chk.sv
`timescale 1ns/1ps
module pit3_chk
    import pit3_pkg::*;
#(
    parameter int NCH      = 3,
    parameter int GATED_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     wr_en,
    input  logic [1:0]               addr,
    input  logic [7:0]               wdata,
    input  logic                     gate_in,
    input  logic [2:0]               tmr_out,
    input  mode_e [NCH-1:0]          ch_mode,
    input  logic [NCH-1:0]           ch_run,
    input  logic [NCH-1:0][CNT_W-1:0] ch_cnt
);
    // R2: select value 3 leaves every counter's mode untouched
    assert_sel3_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTL_ADDR && wdata[7:6] == 2'b11) |=> $stable(ch_mode));

    // R9: gated counter holds its count while the gate is low
    assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_in && !wr_en) |=> $stable(ch_cnt[GATED_CH]));

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        logic gate_k;
        assign gate_k = (k == GATED_CH) ? gate_in : 1'b1;

        // R2: a control word halts the selected counter
        assert_ctl_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CTL_ADDR && wdata[7:6] == 2'(k) && wdata[5:4] != 2'b00)
            |=> !ch_run[k]);

        // R6: terminal-count flag stays high until software intervenes
        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[k] == MD_FLAG && tmr_out[k] && !wr_en) |=> tmr_out[k]);

        // R7: strobe low phase lasts one tick
        assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mode[k] == MD_STROBE && ch_run[k] && !tmr_out[k] && tick && gate_k && !wr_en)
            |=> tmr_out[k]);
    end
endmodule

bind pit3_top pit3_chk #(.NCH(NCH), .GATED_CH(GATED_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .gate_in (gate_in),
    .tmr_out (tmr_out),
    .ch_mode (ch_mode),
    .ch_run  (ch_run),
    .ch_cnt  (ch_cnt)
);

// File: tb/pit3_top_tb.sv
`timescale 1ns/1ps
module pit3_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       gate_in = 1'b1;
    logic [2:0] tmr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pit3_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .gate_in(gate_in), .tmr_out(tmr_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        chk("R1 outputs after reset", tmr_out, 3'b000);
        for (int k = 0; k < 3; k++) rd_chk(2'(k), 8'h00, "R1 count after reset");
    endtask

    task automatic t_flag;
        wr(3, 8'h30);
        chk("R2 mode0 control sets low", tmr_out[0], 1'b0);
        wr(0, 8'h05);
        ticks(3);                       // only low byte present: no counting (R3)
        wr(0, 8'h00);
        ticks(4);
        chk("R6 still low before terminal", tmr_out[0], 1'b0);
        rd_chk(0, 8'h01, "R3 low byte first");
        rd_chk(0, 8'h00, "R3 high byte second");
        ticks(1);
        chk("R6 high at terminal count", tmr_out[0], 1'b1);
        ticks(2);
        chk("R6 stays high after wrap", tmr_out[0], 1'b1);
        rd_chk(0, 8'hFE, "R6 wrap low byte");
        rd_chk(0, 8'hFF, "R6 wrap high byte");
    endtask

    task automatic t_ctl_stop;
        wr(3, 8'h30); wr(0, 8'h03); wr(0, 8'h00);
        ticks(1);
        wr(3, 8'h30);
        ticks(5);
        chk("R2 control word halts counting", tmr_out[0], 1'b0);
    endtask

    task automatic t_bytes;
        wr(3, 8'h54);
        chk("R2 mode2 control sets high", tmr_out[1], 1'b1);
        wr(1, 8'h07);
        rd_chk(1, 8'h07, "R4 low-only load/read");
        wr(3, 8'h64);
        wr(1, 8'h01);
        rd_chk(1, 8'h01, "R4 high-only load/read");
        ticks(1);
        rd_chk(1, 8'h00, "R4 high-only read after tick");
    endtask

    task automatic t_strobe;
        wr(3, 8'h54); wr(1, 8'h04);
        for (int i = 1; i <= 8; i++) begin
            ticks(1);
            chk($sformatf("R7 strobe tick %0d", i), tmr_out[1], (i % 4 == 3) ? 1'b0 : 1'b1);
        end
    endtask

    task automatic t_square;
        wr(3, 8'h36); wr(0, 8'h05); wr(0, 8'h00);
        chk("R8 square starts high", tmr_out[0], 1'b1);
        for (int i = 1; i <= 10; i++) begin
            ticks(1);
            chk($sformatf("R8 odd square tick %0d", i), tmr_out[0],
                (i % 5 == 3 || i % 5 == 4) ? 1'b0 : 1'b1);
        end
        wr(3, 8'h36); wr(0, 8'h04); wr(0, 8'h00);
        for (int i = 1; i <= 8; i++) begin
            ticks(1);
            chk($sformatf("R8 even square tick %0d", i), tmr_out[0],
                (i % 4 == 2 || i % 4 == 3) ? 1'b0 : 1'b1);
        end
    endtask

    task automatic t_snap;
        wr(3, 8'h30); wr(0, 8'h34); wr(0, 8'h12);
        wr(3, 8'h00);
        ticks(3);
        rd_chk(0, 8'h34, "R5 frozen low byte");
        rd_chk(0, 8'h12, "R5 frozen high byte");
        rd_chk(0, 8'h31, "R5 live low after release");
        rd_chk(0, 8'h12, "R5 live high after release");
        wr(3, 8'h00);
        ticks(2);
        wr(3, 8'h00);                   // ignored: snapshot still held
        ticks(1);
        rd_chk(0, 8'h31, "R5 second request ignored low");
        rd_chk(0, 8'h12, "R5 second request ignored high");
        rd_chk(0, 8'h2E, "R5 counting continued low");
        rd_chk(0, 8'h12, "R5 counting continued high");
        wr(3, 8'h50); wr(1, 8'h20);
        wr(3, 8'h40);
        ticks(5);
        rd_chk(1, 8'h20, "R5 low-only frozen read");
        rd_chk(1, 8'h1B, "R5 low-only released after one read");
    endtask

    task automatic t_gate;
        gate_in = 1'b0;
        wr(3, 8'hB0); wr(2, 8'h03); wr(2, 8'h00);
        ticks(5);
        chk("R9 gate low holds output", tmr_out[2], 1'b0);
        rd_chk(2, 8'h03, "R9 gate low holds count low");
        rd_chk(2, 8'h00, "R9 gate low holds count high");
        gate_in = 1'b1;
        ticks(2);
        chk("R9 gate high counts", tmr_out[2], 1'b0);
        ticks(1);
        chk("R9 gate high reaches terminal", tmr_out[2], 1'b1);
    endtask

    task automatic t_sel3;
        wr(3, 8'h50); wr(1, 8'h04);
        wr(3, 8'hF0);
        ticks(4);
        chk("R2 select 3 ignored", tmr_out[1], 1'b1);
    endtask

    task automatic t_alias;
        wr(3, 8'h72);
        chk("R11 mode1 as mode0 low", tmr_out[1], 1'b0);
        wr(1, 8'h02); wr(1, 8'h00);
        ticks(1);
        chk("R11 mode1 before terminal", tmr_out[1], 1'b0);
        ticks(1);
        chk("R11 mode1 terminal", tmr_out[1], 1'b1);
        wr(3, 8'h5C); wr(1, 8'h03);
        ticks(1);
        chk("R11 mode6 tick1", tmr_out[1], 1'b1);
        ticks(1);
        chk("R11 mode6 tick2 strobe", tmr_out[1], 1'b0);
        ticks(1);
        chk("R11 mode6 tick3", tmr_out[1], 1'b1);
    endtask

    task automatic t_bcd;
        wr(3, 8'h31); wr(0, 8'h10); wr(0, 8'h00);
        ticks(1);
        rd_chk(0, 8'h0F, "R12 decimal flag counts binary");
    endtask

    task automatic t_zero;
        wr(3, 8'h30); wr(0, 8'h00); wr(0, 8'h00);
        ticks(65535);
        chk("R10 zero count not yet done", tmr_out[0], 1'b0);
        ticks(1);
        chk("R10 zero count is 65536", tmr_out[0], 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flag();
        t_ctl_stop();
        t_bytes();
        t_strobe();
        t_square();
        t_snap();
        t_gate();
        t_sel3();
        t_alias();
        t_bcd();
        t_zero();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule